// File: doc/BRIEF.md
# Cycle-Divided Scanline Interrupt Timer

This block raises a scanline-aligned interrupt without watching the video bus. It counts CPU clock cycles and turns them into line periods. In the default line mode the divider walks a three-phase cycle of 114, 114 and 113 clocks, which averages to 113 2/3 clocks per line. In the second line mode it walks sixteen phases of 106 or 107 clocks, which averages to 106 9/16 clocks per line. Each completed line period takes one from an 8-bit line count. When that count reaches zero, the active-low interrupt output goes low and stays low until software acknowledges it.

Software drives the block through a small write port. A write to the reload register loads the line count, returns the divider to phase 0 with its cycle count at 0, and arms the counter. A write to the control register sets the enable and the line mode. A write to the acknowledge register releases the interrupt. The counter does not run freely from frame to frame, because one line in every other frame is a dot shorter. Software therefore writes the reload value once per frame.

The counter has two states, CNT_IDLE and CNT_RUN. A reload write with a non-zero value takes it from CNT_IDLE to CNT_RUN (transition ARM). The line tick that takes the count from 1 to 0 returns it to CNT_IDLE (transition EXPIRE). A reload write of zero also returns it to CNT_IDLE (transition DISARM). The interrupt latch has two states, IRQ_IDLE and IRQ_RAISED. An expiry takes it from IRQ_IDLE to IRQ_RAISED (transition RAISE). An acknowledge write, or a control write that clears the enable, takes it back to IRQ_IDLE (transition RELEASE). The divider phases are numbered. In line mode 0 they run 0, 1, 2 and back to 0. In line mode 1 they run 0 to 15 and back to 0. Each phase moves to the next on a line tick (transition STEP).

Top module: `scanline_irq_timer`

## Requirements
- R1: After reset, irq_n is 1, the counter is in CNT_IDLE, the enable is 0 and line mode 0 is selected. While the enable is 0, a reload write does not lead to an interrupt.
- R2: In line mode 0 (control bit 1 = 0), line periods follow the sequence 114, 114, 113 clocks, starting from phase 0 at the reload. A reload of N with the enable set drives irq_n low N periods later; for example, 3 lines take 341 clocks and 255 lines take 28985 clocks.
- R3: In line mode 1 (control bit 1 = 1), phase p of 16 (p = 0 to 15) lasts 107 clocks when floor((p+1)*9/16) differs from floor(p*9/16), and 106 clocks otherwise. For example, 2 lines take 213 clocks and 16 lines take 1705 clocks.
- R4: A write with wr_sel = 0 loads wr_data as the line count and resets the phase and the cycle count to 0. A reload written while the counter runs restarts the timing from that write, and the reload takes priority over a line tick in the same cycle.
- R5: irq_n goes low at the clock edge where the count moves from 1 to 0 while the enable is set, and it stays low until it is released.
- R6: A write with wr_sel = 2 sets irq_n to 1 at the next edge. Such a write has no effect when no interrupt is pending, and it does not disturb a count in progress.
- R7: A control write (wr_sel = 1) with bit 0 = 0 sets irq_n to 1 and freezes the divider and the count. Setting bit 0 again resumes the timing from the point where it stopped.
- R8: After an expiry the counter stays idle, and no further interrupt occurs until the next reload.
- R9: A reload value of 0 leaves the counter idle, and no interrupt follows.
- R10: A write with wr_sel = 3 has no effect on the count, the timing, the enable or the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock; each rising edge is one counted cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Register select: 0 reload, 1 control, 2 acknowledge, 3 unused |
| wr_data | input | 8 | Write data; on control writes, bit 0 is the enable and bit 1 the line mode |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest situations to reach are the long phase sequences. The sixteen-phase mode only shows its full pattern of long and short phases over a complete cycle of 1705 clocks. A full 255-line count in the three-phase mode runs for nearly 29000 clocks. The bench reaches both with a single reload and then waits them out, while a behavioural model tracks every cycle. It also stops the enable partway through a line and later restores it, so the frozen divider has to resume in the correct phase. Finally, it places a reload in the middle of a running count to show that the restart takes priority.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;

    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_ACK    = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        CNT_IDLE = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    typedef enum logic {
        LINE_MODE0 = 1'b0,
        LINE_MODE1 = 1'b1
    } line_mode_e;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import scanline_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              reload_wr,
    output logic [DATA_W-1:0] reload_val,
    output logic              ack_wr,
    output logic              ctrl_wr,
    output logic              disable_wr,
    output logic              enable,
    output line_mode_e        mode
);

    reg_sel_e sel;

    always_comb begin
        sel        = reg_sel_e'(wr_sel);
        reload_wr  = 1'b0;
        ack_wr     = 1'b0;
        ctrl_wr    = 1'b0;
        reload_val = wr_data;
        if (wr_en) begin
            unique case (sel)
                SEL_RELOAD: reload_wr = 1'b1;
                SEL_CTRL:   ctrl_wr   = 1'b1;
                SEL_ACK:    ack_wr    = 1'b1;
                SEL_SPARE:  ;
            endcase
        end
        disable_wr = ctrl_wr && !wr_data[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable <= 1'b0;
            mode   <= LINE_MODE0;
        end else if (ctrl_wr) begin
            enable <= wr_data[0];
            mode   <= wr_data[1] ? LINE_MODE1 : LINE_MODE0;
        end
    end

    // R10: the unused select leaves control state alone
    p_spare_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> ($stable(enable) && $stable(mode)))
        else $error("spare write changed control");

endmodule

// File: rtl/line_prescaler.sv
module line_prescaler
    import scanline_irq_pkg::*;
#(
    parameter int NTSC_LONG   = 114,
    parameter int NTSC_PHASES = 3,
    parameter int PAL_BASE    = 106,
    parameter int PAL_PHASES  = 16,
    parameter int PAL_EXTRA   = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  line_mode_e mode,
    output logic       line_tick
);

    localparam int CYC_W  = $clog2(NTSC_LONG);
    localparam int PH_MAX = (PAL_PHASES > NTSC_PHASES) ? PAL_PHASES : NTSC_PHASES;
    localparam int PH_W   = $clog2(PH_MAX);

    logic [PH_W-1:0]  phase_q, phase_d;
    logic [CYC_W-1:0] cyc_q, cyc_d, last_cyc;
    logic             wrap;

    function automatic logic [CYC_W-1:0] mode1_last(input logic [PH_W-1:0] p);
        int lo, hi;
        lo = (int'(p) * PAL_EXTRA) / PAL_PHASES;
        hi = ((int'(p) + 1) * PAL_EXTRA) / PAL_PHASES;
        return CYC_W'(PAL_BASE - 1 + ((hi != lo) ? 1 : 0));
    endfunction

    always_comb begin
        unique case (mode)
            LINE_MODE0: begin
                wrap     = (phase_q >= PH_W'(NTSC_PHASES - 1));
                last_cyc = wrap ? CYC_W'(NTSC_LONG - 2) : CYC_W'(NTSC_LONG - 1);
            end
            LINE_MODE1: begin
                wrap     = (phase_q >= PH_W'(PAL_PHASES - 1));
                last_cyc = mode1_last(phase_q);
            end
        endcase
        line_tick = run && (cyc_q >= last_cyc);
    end

    always_comb begin
        phase_d = phase_q;
        cyc_d   = cyc_q;
        if (restart) begin
            phase_d = '0;
            cyc_d   = '0;
        end else if (line_tick) begin
            phase_d = wrap ? '0 : phase_q + 1'b1;
            cyc_d   = '0;
        end else if (run) begin
            cyc_d   = cyc_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            cyc_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cyc_q   <= cyc_d;
        end
    end

    // R2: the cycle count never passes the longest line
    p_cyc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_q < CYC_W'(NTSC_LONG))
        else $error("cycle count overran");

    // R4: a reload returns the divider to its origin
    p_restart_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase_q == '0 && cyc_q == '0))
        else $error("restart did not clear divider");

    // R7: a stopped divider holds its place
    p_frozen_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> ($stable(cyc_q) && $stable(phase_q)))
        else $error("divider moved while stopped");

    // R3: mode 1 phases stay within the sixteen-phase range
    p_mode1_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LINE_MODE1 && line_tick && !restart && phase_q == PH_W'(PAL_PHASES - 1))
        |=> phase_q == '0)
        else $error("mode 1 phase did not wrap");

endmodule

// File: rtl/scanline_down_counter.sv
module scanline_down_counter
    import scanline_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             line_tick,
    output logic             running,
    output logic             expire
);

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_IDLE;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        unique case (state_q)
            CNT_IDLE: begin
                if (load) begin
                    count_d = load_val;
                    if (load_val != '0) state_d = CNT_RUN;
                end
            end
            CNT_RUN: begin
                if (load) begin
                    count_d = load_val;
                    if (load_val == '0) state_d = CNT_IDLE;
                end else if (line_tick) begin
                    count_d = count_q - 1'b1;
                    if (count_q == CNT_W'(1)) state_d = CNT_IDLE;
                end
            end
        endcase
    end

    always_comb begin
        running = (state_q == CNT_RUN);
        expire  = (state_q == CNT_RUN) && line_tick && !load && (count_q == CNT_W'(1));
    end

    // R4: a reload lands in the count
    p_load_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count_q == $past(load_val))
        else $error("reload value lost");

    // R8: an idle counter stays idle without a reload
    p_idle_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_IDLE && !load) |=> state_q == CNT_IDLE)
        else $error("counter restarted by itself");

    // R9: a zero reload disarms
    p_zero_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> state_q == CNT_IDLE)
        else $error("zero reload armed counter");

    // R7: without ticks the count holds
    p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !line_tick) |=> $stable(count_q))
        else $error("count moved without tick");

endmodule

// File: rtl/irq_hold.sv
module irq_hold
    import scanline_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clear,
    output logic irq_n
);

    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (set && !clear) state_d = IRQ_RAISED;
            IRQ_RAISED: if (clear)         state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq_n = (state_q != IRQ_RAISED);
    end

    // R5: an expiry pulls the line low
    p_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !clear) |=> !irq_n)
        else $error("expiry did not raise");

    // R5: a raised request holds until released
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !clear) |=> !irq_n)
        else $error("request dropped early");

    // R6: a release always frees the line
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> irq_n)
        else $error("release ignored");

endmodule

// File: rtl/scanline_irq_timer.sv
module scanline_irq_timer
    import scanline_irq_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int NTSC_LONG   = 114,
    parameter int NTSC_PHASES = 3,
    parameter int PAL_BASE    = 106,
    parameter int PAL_PHASES  = 16,
    parameter int PAL_EXTRA   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             irq_n
);

    logic             reload_wr, ack_wr, ctrl_wr, disable_wr, enable;
    logic [CNT_W-1:0] reload_val;
    line_mode_e       mode;
    logic             line_tick, running, expire, div_run, irq_clear;

    irq_reg_decode #(.DATA_W(CNT_W)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .reload_wr  (reload_wr),
        .reload_val (reload_val),
        .ack_wr     (ack_wr),
        .ctrl_wr    (ctrl_wr),
        .disable_wr (disable_wr),
        .enable     (enable),
        .mode       (mode)
    );

    always_comb begin
        div_run   = running && enable;
        irq_clear = ack_wr || disable_wr;
    end

    line_prescaler #(
        .NTSC_LONG   (NTSC_LONG),
        .NTSC_PHASES (NTSC_PHASES),
        .PAL_BASE    (PAL_BASE),
        .PAL_PHASES  (PAL_PHASES),
        .PAL_EXTRA   (PAL_EXTRA)
    ) u_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (reload_wr),
        .run       (div_run),
        .mode      (mode),
        .line_tick (line_tick)
    );

    scanline_down_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (reload_wr),
        .load_val  (reload_val),
        .line_tick (line_tick),
        .running   (running),
        .expire    (expire)
    );

    irq_hold u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (expire),
        .clear (irq_clear),
        .irq_n (irq_n)
    );

    // R7: clearing the enable frees the interrupt line
    p_disable_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && !wr_data[0]) |=> irq_n)
        else $error("disable did not release");

    // R1: nothing expires while the enable is off
    p_no_expire_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !expire)
        else $error("expiry while disabled");

    // R6: an acknowledge write does not stop the count
    p_ack_keeps_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && running && !line_tick) |=> running)
        else $error("acknowledge disturbed count");

endmodule

// File: tb/scanline_irq_timer_test.sv
`timescale 1ns/1ps
module scanline_irq_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       irq_n;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    compare_on = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    scanline_irq_timer uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .irq_n   (irq_n)
    );

    // behavioural reference
    int m_en, m_mode1, m_armed, m_cnt, m_ph, m_cyc, m_irq;

    function automatic int line_len(int ph, int mode1);
        int acc;
        if (mode1 != 0) begin
            acc = 0;
            for (int k = 0; k < ph; k++) acc = (acc + 9) % 16;
            return (acc + 9 >= 16) ? 107 : 106;
        end
        return (ph >= 2) ? 113 : 114;
    endfunction

    function automatic int next_ph(int ph, int mode1);
        if (mode1 != 0) return (ph >= 15) ? 0 : ph + 1;
        return (ph >= 2) ? 0 : ph + 1;
    endfunction

    always @(posedge clk) begin
        int  tick, expd, clr;
        if (!rst_n) begin
            m_en = 0; m_mode1 = 0; m_armed = 0; m_cnt = 0; m_ph = 0; m_cyc = 0; m_irq = 0;
        end else begin
            tick = (m_armed != 0 && m_en != 0 && m_cyc >= line_len(m_ph, m_mode1) - 1) ? 1 : 0;
            expd = 0;
            if (wr_en && wr_sel == 2'd0) begin
                m_cnt = int'(wr_data); m_ph = 0; m_cyc = 0;
                m_armed = (wr_data != 8'd0) ? 1 : 0;
            end else if (m_armed != 0 && m_en != 0) begin
                if (tick != 0) begin
                    m_cyc = 0;
                    m_ph  = next_ph(m_ph, m_mode1);
                    if (m_cnt == 1) expd = 1;
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) m_armed = 0;
                end else begin
                    m_cyc = m_cyc + 1;
                end
            end
            clr = (wr_en && (wr_sel == 2'd2 || (wr_sel == 2'd1 && !wr_data[0]))) ? 1 : 0;
            if (clr != 0)       m_irq = 0;
            else if (expd != 0) m_irq = 1;
            if (wr_en && wr_sel == 2'd1) begin
                m_en = wr_data[0] ? 1 : 0;
                m_mode1 = wr_data[1] ? 1 : 0;
            end
        end
    end

    always @(negedge clk) begin
        if (compare_on && !finished) begin
            n_checks++;
            if (irq_n !== ((m_irq != 0) ? 1'b0 : 1'b1)) begin
                n_fails++;
                $display("FAIL %s per-cycle irq_n actual=%b expected=%b at %0t",
                         cur_req, irq_n, (m_irq == 0), $time);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'd0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wait_irq(output int k);
        k = 0;
        while (irq_n === 1'b1 && k < 40000) begin
            @(posedge clk); @(negedge clk); k++;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int k;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        compare_on = 1'b1;

        cur_req = "R1";
        check(irq_n === 1'b1, "R1 reset irq_n", int'(irq_n), 1);
        write_reg(2'd0, 8'd1);
        idle(300);
        check(irq_n === 1'b1, "R1 disabled after reset", int'(irq_n), 1);

        cur_req = "R2";
        write_reg(2'd1, 8'h01);
        write_reg(2'd0, 8'd3);
        wait_irq(k);
        check(k == 341, "R2 three lines mode 0", k, 341);

        cur_req = "R5";
        idle(500);
        check(irq_n === 1'b0, "R5 held low", int'(irq_n), 0);

        cur_req = "R6";
        write_reg(2'd2, 8'd0);
        check(irq_n === 1'b1, "R6 acknowledge release", int'(irq_n), 1);

        cur_req = "R8";
        idle(400);
        check(irq_n === 1'b1, "R8 no re-raise", int'(irq_n), 1);

        cur_req = "R6";
        write_reg(2'd2, 8'd0);
        write_reg(2'd0, 8'd1);
        idle(20);
        write_reg(2'd2, 8'd0);
        wait_irq(k);
        check(k == 114 - 21, "R6 ack mid-count", k, 93);
        write_reg(2'd2, 8'd0);

        cur_req = "R3";
        write_reg(2'd1, 8'h03);
        write_reg(2'd0, 8'd2);
        wait_irq(k);
        check(k == 213, "R3 two lines mode 1", k, 213);
        write_reg(2'd2, 8'd0);
        write_reg(2'd0, 8'd16);
        wait_irq(k);
        check(k == 1705, "R3 sixteen lines mode 1", k, 1705);
        write_reg(2'd2, 8'd0);

        cur_req = "R2";
        write_reg(2'd1, 8'h01);
        write_reg(2'd0, 8'd255);
        wait_irq(k);
        check(k == 28985, "R2 full count mode 0", k, 28985);
        write_reg(2'd2, 8'd0);

        cur_req = "R4";
        write_reg(2'd0, 8'd2);
        idle(150);
        write_reg(2'd0, 8'd1);
        wait_irq(k);
        check(k == 114, "R4 reload restarts", k, 114);
        write_reg(2'd2, 8'd0);

        cur_req = "R7";
        write_reg(2'd0, 8'd3);
        idle(100);
        write_reg(2'd1, 8'h00);
        idle(60);
        check(irq_n === 1'b1, "R7 frozen no irq", int'(irq_n), 1);
        write_reg(2'd1, 8'h01);
        wait_irq(k);
        check(k == 240, "R7 resume after freeze", k, 240);
        write_reg(2'd1, 8'h00);
        check(irq_n === 1'b1, "R7 disable releases", int'(irq_n), 1);

        cur_req = "R9";
        write_reg(2'd1, 8'h01);
        write_reg(2'd0, 8'd0);
        idle(500);
        check(irq_n === 1'b1, "R9 zero reload idle", int'(irq_n), 1);

        cur_req = "R10";
        write_reg(2'd0, 8'd1);
        idle(30);
        write_reg(2'd3, 8'h00);
        wait_irq(k);
        check(k == 114 - 31, "R10 spare write ignored", k, 83);
        write_reg(2'd2, 8'd0);
        idle(10);

        finish_run();
    end

endmodule